// File: doc/BRIEF.md
# SIMT Execution Mask Reconvergence Stack

This block is the control-flow unit of one wave in a SIMT core. It keeps the active-lane execution mask and a bounded stack of saved (mask, address) pairs. Each cycle it takes one mask-control operation, together with the per-lane condition bits from the datapath and the current program counter. From these it produces the next execution mask and the next program counter. That next PC is the sequential address, a branch target, or an address popped from the stack. Diverged lanes come back together at a reconvergence point through two rules: a pop when no lane stays active, and a fall-through to the else path when no lane takes the then path.

The datapath asks for a lane write with a single request bit. The block gates that request with the mask, so a lane that is switched off has no register state changed. Two sticky flags report a push onto a full stack and a pop from an empty one.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, `exec_mask` is all ones, `next_pc` is 0, the stack is empty and both flags are clear.
- R2: `wr_lanes` equals `exec_mask` while `wr_req` is 1 and is all zeros while `wr_req` is 0, in the same cycle.
- R3: Every result is registered and visible after the clock edge that takes the operation. With `op`=0 (no-op), the mask is unchanged and `next_pc` becomes `pc_in`+1. Every operation not listed below as redirecting also gives `pc_in`+1.
- R4: `op`=1 (push) stores the current mask with `tgt` as the reconvergence address and leaves the mask unchanged.
- R5: `op`=2 (pop) takes the most recently pushed entry (last in, first out), loads its mask into `exec_mask` and its address into `next_pc`.
- R6: A pop with the stack empty sets the sticky `underflow` flag, leaves the mask unchanged and gives `pc_in`+1.
- R7: `op`=3 (mask on nonzero) with `exec_mask & cond` not zero loads that value into the mask.
- R8: `op`=3 with `exec_mask & cond` equal to zero behaves exactly as a pop.
- R9: `op`=4 (branch push) with lanes on both sides pushes (mask, `conv`) and then (mask & ~cond, `tgt`). It sets the mask to mask & cond and gives `pc_in`+1.
- R10: `op`=4 with no lane on the else side pushes only (mask, `conv`) and sets the mask to mask & cond.
- R11: `op`=4 with no lane on the then side pushes only (mask, `conv`). It sets the mask to mask & ~cond and `next_pc` to `tgt`.
- R12: A push or branch push whose entries do not all fit in `DEPTH` entries writes none of them and sets the sticky `overflow` flag. The mask and PC still update as for an operation that fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 mask on nonzero, 4 branch push |
| cond | input | LANES | Per-lane condition bits (1 = nonzero) |
| tgt | input | AW | Push reconvergence address, or else-path address for branch push |
| conv | input | AW | Reconvergence address for branch push |
| pc_in | input | AW | PC of the current operation |
| wr_req | input | 1 | Datapath asks to write lane registers |
| exec_mask | output | LANES | Registered execution mask |
| wr_lanes | output | LANES | Per-lane register write enable |
| next_pc | output | AW | Registered next program counter |
| overflow | output | 1 | Sticky: push onto a full stack |
| underflow | output | 1 | Sticky: pop from an empty stack |

## Verification
A corrupted stack pointer or entry stays hidden until a pop reaches it. It then shows up as a wrong mask or a wrong `next_pc` one cycle after that pop, or as a flag that rises too early or too late. The bench therefore keeps its own model of the stack and compares mask, PC and both flags after every operation. Each push sequence is drained to the bottom and one step past it, so that stale or misordered entries surface at the ports.

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [LANES-1:0] cond,
  input  logic [AW-1:0]    tgt,
  input  logic [AW-1:0]    conv,
  input  logic [AW-1:0]    pc_in,
  input  logic             wr_req,
  output logic [LANES-1:0] exec_mask,
  output logic [LANES-1:0] wr_lanes,
  output logic [AW-1:0]    next_pc,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [2:0] OP_NOP = 3'd0, OP_PUSH = 3'd1, OP_POP = 3'd2,
                         OP_MNZ = 3'd3, OP_BR = 3'd4;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SPW:0] DEP = (SPW+1)'(DEPTH);

  logic [LANES-1:0] stk_m [DEPTH];
  logic [AW-1:0]    stk_a [DEPTH];
  logic [SPW-1:0]   sp;

  wire [LANES-1:0] m_then = exec_mask & cond;
  wire [LANES-1:0] m_else = exec_mask & ~cond;
  wire             two    = (op == OP_BR) && (m_then != '0) && (m_else != '0);
  wire [1:0]       need   = two ? 2'd2 : 2'd1;
  wire             fits   = ({1'b0, sp} + (SPW+1)'(need)) <= DEP;
  wire             do_pop = (op == OP_POP) || (op == OP_MNZ && m_then == '0);
  wire             empty  = (sp == '0);
  wire [IW-1:0]    wi     = IW'(sp);
  wire [IW-1:0]    wi1    = IW'(sp + 1'b1);
  wire [IW-1:0]    ti     = IW'(sp - 1'b1);

  assign wr_lanes = wr_req ? exec_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_mask <= '1;
      next_pc   <= '0;
      sp        <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      next_pc <= pc_in + 1'b1;
      if (op == OP_PUSH || op == OP_BR) begin
        if (fits) begin
          stk_m[wi] <= exec_mask;
          stk_a[wi] <= (op == OP_BR) ? conv : tgt;
          if (two) begin
            stk_m[wi1] <= m_else;
            stk_a[wi1] <= tgt;
          end
          sp <= sp + SPW'(need);
        end else begin
          overflow <= 1'b1;
        end
      end
      if (op == OP_BR) begin
        if (m_then != '0) exec_mask <= m_then;
        else begin
          exec_mask <= m_else;
          next_pc   <= tgt;
        end
      end
      if (op == OP_MNZ && m_then != '0) exec_mask <= m_then;
      if (do_pop) begin
        if (empty) underflow <= 1'b1;
        else begin
          exec_mask <= stk_m[ti];
          next_pc   <= stk_a[ti];
          sp        <= sp - 1'b1;
        end
      end
    end
  end

  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_udf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  p_sp_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, sp} <= DEP));
  p_nop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> (exec_mask == $past(exec_mask)) && (next_pc == $past(pc_in) + 1'b1));
  p_mnz_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MNZ && (exec_mask & cond) != '0) |=> ((exec_mask & ~$past(exec_mask)) == '0));
  p_br_then_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BR && (exec_mask & cond) != '0) |=> (exec_mask == $past(exec_mask & cond)));
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && empty) |=> (exec_mask == $past(exec_mask)) && underflow);
endmodule

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;
  localparam int LANES = 8, DEPTH = 4, AW = 16;
  logic clk = 0, rst_n = 0, wr_req = 0;
  logic [2:0] op = 0;
  logic [LANES-1:0] cond = 0;
  logic [AW-1:0] tgt = 0, conv = 0, pc_in = 0;
  logic [LANES-1:0] exec_mask, wr_lanes;
  logic [AW-1:0] next_pc;
  logic overflow, underflow;
  int errors = 0, checks = 0;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) i_simt_mask_stack (
    .clk, .rst_n, .op, .cond, .tgt, .conv, .pc_in, .wr_req,
    .exec_mask, .wr_lanes, .next_pc, .overflow, .underflow);

  always #2 clk = ~clk;

  logic [LANES-1:0] em, sm [DEPTH];
  logic [AW-1:0] epc, sa [DEPTH];
  int esp;
  logic eovf, eudf;

  task automatic chk(string tag);
    checks++;
    if (exec_mask !== em || next_pc !== epc || overflow !== eovf || underflow !== eudf) begin
      errors++;
      $display("FAIL %s: mask=%h pc=%h ovf=%b udf=%b expected mask=%h pc=%h ovf=%b udf=%b",
               tag, exec_mask, next_pc, overflow, underflow, em, epc, eovf, eudf);
    end
  endtask

  task automatic model_pop();
    if (esp == 0) eudf = 1;
    else begin esp--; em = sm[esp]; epc = sa[esp]; end
  endtask

  task automatic model(input logic [2:0] o, input logic [LANES-1:0] c,
                       input logic [AW-1:0] t, input logic [AW-1:0] cv, input logic [AW-1:0] p);
    logic [LANES-1:0] th, el;
    int n;
    th = em & c; el = em & ~c;
    epc = p + 1'b1;
    case (o)
      3'd1: if (esp < DEPTH) begin sm[esp] = em; sa[esp] = t; esp++; end else eovf = 1;
      3'd2: model_pop();
      3'd3: if (th != 0) em = th; else model_pop();
      3'd4: begin
        n = (th != 0 && el != 0) ? 2 : 1;
        if (esp + n <= DEPTH) begin
          sm[esp] = em; sa[esp] = cv; esp++;
          if (n == 2) begin sm[esp] = el; sa[esp] = t; esp++; end
        end else eovf = 1;
        if (th != 0) em = th; else begin em = el; epc = t; end
      end
      default: ;
    endcase
  endtask

  task automatic do_op(string tag, input logic [2:0] o, input logic [LANES-1:0] c,
                       input logic [AW-1:0] t, input logic [AW-1:0] cv, input logic [AW-1:0] p);
    @(negedge clk);
    op = o; cond = c; tgt = t; conv = cv; pc_in = p;
    model(o, c, t, cv, p);
    @(posedge clk); #1;
    chk(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; op = 0;
    @(posedge clk); #1;
    em = '1; epc = 0; esp = 0; eovf = 0; eudf = 0;
    chk("R1 reset");
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] ro;
    void'($urandom(1234));
    do_reset();
    // R2: write gating
    @(negedge clk); wr_req = 1; #1; checks++;
    if (wr_lanes !== exec_mask) begin errors++; $display("FAIL R2: wr_lanes=%h expected %h", wr_lanes, exec_mask); end
    wr_req = 0; #1; checks++;
    if (wr_lanes !== '0) begin errors++; $display("FAIL R2: wr_lanes=%h expected 00", wr_lanes); end
    do_op("R3 nop", 3'd0, 8'h55, 16'h0, 16'h0, 16'h0007);
    // R9 both sides, then drain
    do_op("R9 br both", 3'd4, 8'h0F, 16'h0040, 16'h0080, 16'h0010);
    do_op("R9 pop else", 3'd2, 8'h00, 16'h0, 16'h0, 16'h0020);
    do_op("R9 pop conv", 3'd2, 8'h00, 16'h0, 16'h0, 16'h0041);
    // R10 only conv entry
    do_op("R10 br all then", 3'd4, 8'hFF, 16'h0050, 16'h0090, 16'h0030);
    do_op("R10 pop conv", 3'd2, 8'h00, 16'h0, 16'h0, 16'h0031);
    do_op("R6 pop empty", 3'd2, 8'h00, 16'h0, 16'h0, 16'h0091);
    do_reset();
    // R11 no then lanes
    do_op("R11 br all else", 3'd4, 8'h00, 16'h0060, 16'h00A0, 16'h0011);
    do_op("R11 pop conv", 3'd2, 8'h00, 16'h0, 16'h0, 16'h0061);
    // R7 / R8
    do_op("R4 push", 3'd1, 8'h00, 16'h00B0, 16'h0, 16'h0012);
    do_op("R7 masknz", 3'd3, 8'h03, 16'h0, 16'h0, 16'h0013);
    do_op("R7 masknz narrow", 3'd3, 8'h02, 16'h0, 16'h0, 16'h0014);
    do_op("R8 masknz zero pops", 3'd3, 8'h01, 16'h0, 16'h0, 16'h0015);
    // R12 overflow and R5 LIFO order
    for (int i = 0; i < DEPTH; i++) begin
      do_op("R4 push fill", 3'd3, 8'hFF >> i, 16'h0, 16'h0, 16'(16'h0100 + i));
      do_op("R4 push fill", 3'd1, 8'h00, 16'(16'h0200 + i), 16'h0, 16'h0101);
    end
    do_op("R12 push full", 3'd1, 8'h00, 16'h0300, 16'h0, 16'h0102);
    do_op("R12 br full", 3'd4, 8'h01, 16'h0310, 16'h0320, 16'h0103);
    for (int i = 0; i < DEPTH; i++) do_op("R5 lifo pop", 3'd2, 8'h00, 16'h0, 16'h0, 16'h0104);
    do_op("R6 pop empty", 3'd2, 8'h00, 16'h0, 16'h0, 16'h0105);
    do_reset();
    do_op("R4 push", 3'd1, 8'h00, 16'h0400, 16'h0, 16'h0001);
    do_op("R12 br needs two", 3'd4, 8'h0F, 16'h0410, 16'h0420, 16'h0002);
    do_op("R12 br needs two", 3'd4, 8'h03, 16'h0430, 16'h0440, 16'h0003);
    do_op("R12 br no room", 3'd4, 8'h01, 16'h0450, 16'h0460, 16'h0004);
    // random mix
    for (int k = 0; k < 600; k++) begin
      if (k % 150 == 0) do_reset();
      ro = 3'($urandom_range(0, 4));
      do_op($sformatf("R%0s random op %0d", ro == 0 ? "3" : ro == 1 ? "4" : ro == 2 ? "5" : ro == 3 ? "7" : "9", ro),
            ro, 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule